// File: doc/BRIEF.md
# Two-Level Masked Interrupt Status Unit

This block gathers single-cycle event pulses from a storage-card host's command and data engines into one 32-bit status word. The upper sixteen bits hold error events and the lower sixteen hold normal events. Masking is done in two stages. A capture-enable word decides whether an event may set its status bit at all. A line-enable word then decides which of the captured bits drive the level interrupt output.

Software clears status bits by writing ones to them. Bit 15 is read-only and derived: it reports that some error bit is set. A soft-clear input empties the status word and leaves both enable words as they are. Access is through a plain register port with a 2-bit address and a combinational read: address 0 is status, address 1 is capture-enable, address 2 is line-enable, and address 3 is unmapped.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse at a mapped position (0 command done, 1 transfer done, 4 write-space ready, 5 read-data ready, 16 command timeout, 17 command CRC, 18 command end bit, 20 data timeout, 21 data CRC, 22 data end bit, 28 card error, 29 bad access) sets that status bit, readable at address 0, on the clock edge that samples it, provided its capture-enable bit is 1.
- R2: An event whose capture-enable bit is 0 leaves its status bit unchanged.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: Status bit 15 reads 1 exactly while any of bits [31:16] is set, and writes to bit 15 have no effect.
- R5: When an event and a write-one clear hit the same bit in the same cycle, the bit stays set.
- R6: The capture-enable word keeps only the mapped positions (mask 0x30770033), and bit 15 always reads 0. The line-enable word keeps the mapped positions plus bit 15 (mask 0x30778033).
- R7: Reserved status positions never become set and read 0, and address 3 reads 0.
- R8: irq_o is registered. One cycle after the status or enable words change, it equals the OR over all bits of (status as read, including bit 15) AND line-enable.
- R9: While soft_clr_i is high, every status bit clears on the next edge and both enable words keep their values.
- R10: After reset, all three words read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_clr_i | input | 1 | Clears the status word, keeps the enables |
| evt_i | input | 32 | Event pulses, one per status position |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 capture-enable, 2 line-enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
A status bit that is stuck or lost appears at address 0 as soon as the edge after the event or clear. A summary bit that is wrong shows up in the same read. An interrupt line that is masked wrongly, or that fails to track the summary bit, differs from the expected level one cycle after the status changes. Enable words that are corrupted by soft clear, or that accept reserved bits, show up on readback at addresses 1 and 2.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_W   = 32;
  localparam int unsigned SUM_BIT = 15;
  localparam logic [IRQ_W-1:0] EVT_MASK = 32'h3077_0033;
  localparam logic [IRQ_W-1:0] SIG_MASK = EVT_MASK | (32'h1 << SUM_BIT);

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_STS_EN = 2'd1,
    ADDR_SIG_EN = 2'd2,
    ADDR_RSVD   = 2'd3
  } irq_addr_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned         W       = 32,
  parameter logic [W-1:0]        WR_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i & WR_MASK;
  end

  assign en_o = en_q;

  // enables move only on their own write, never on soft clear
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_o)) else $error("enable changed without write"); // R9
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] EVT_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] sts_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (EVT_MASK[i]) begin : g_cell
      logic q;
      logic set;
      assign set = evt_i[i] & sts_en_i[i];

      // event beats same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= 1'b0;
        else if (soft_clr_i) q <= 1'b0;
        else if (set)        q <= 1'b1;
        else if (clr_i[i])   q <= 1'b0;
      end
      assign sts_o[i] = q;

      AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[i] && sts_en_i[i] && !soft_clr_i) |=> sts_o[i]) else $error("event lost"); // R5
      AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !evt_i[i]) |=> !sts_o[i]) else $error("clear failed"); // R3
      AST_MASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sts_o[i] && !(evt_i[i] && sts_en_i[i])) |=> !sts_o[i]) else $error("masked set"); // R2
    end else begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end
  end

  AST_SOFT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (sts_o == '0)) else $error("soft clear missed"); // R9
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] view_i,
  input  logic [W-1:0] sig_en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(view_i & sig_en_i);
  end

  assign irq_o = irq_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|sig_en_i)) else $error("irq without enable"); // R8
  AST_IRQ_NEEDS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|view_i)) else $error("irq without status"); // R8
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int unsigned W = IRQ_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic [W-1:0] evt_i,
  input  logic         reg_we_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_o
);
  localparam int unsigned ERR_LO = W / 2;

  logic [W-1:0] sts_en, sig_en, sts, view, clr;
  logic         we_sts_en, we_sig_en, summary;

  assign we_sts_en = reg_we_i && (reg_addr_i == ADDR_STS_EN);
  assign we_sig_en = reg_we_i && (reg_addr_i == ADDR_SIG_EN);
  assign clr = (reg_we_i && reg_addr_i == ADDR_STATUS) ? reg_wdata_i : '0;

  irq_enable_reg #(.W(W), .WR_MASK(EVT_MASK[W-1:0])) u_sts_en (
    .clk_i, .rst_ni, .we_i(we_sts_en), .wdata_i(reg_wdata_i), .en_o(sts_en)
  );

  irq_enable_reg #(.W(W), .WR_MASK(SIG_MASK[W-1:0])) u_sig_en (
    .clk_i, .rst_ni, .we_i(we_sig_en), .wdata_i(reg_wdata_i), .en_o(sig_en)
  );

  irq_status_reg #(.W(W), .EVT_MASK(EVT_MASK[W-1:0])) u_sts (
    .clk_i, .rst_ni, .soft_clr_i, .evt_i, .sts_en_i(sts_en), .clr_i(clr), .sts_o(sts)
  );

  assign summary = |sts[W-1:ERR_LO];

  always_comb begin
    view = sts;
    view[SUM_BIT] = summary;
  end

  irq_line #(.W(W)) u_line (
    .clk_i, .rst_ni, .view_i(view), .sig_en_i(sig_en), .irq_o
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_STATUS: reg_rdata_o = view;
      ADDR_STS_EN: reg_rdata_o = sts_en;
      ADDR_SIG_EN: reg_rdata_o = sig_en;
      default:     reg_rdata_o = '0;
    endcase
  end

  AST_RSVD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_RSVD) |-> (reg_rdata_o == '0)) else $error("rsvd addr"); // R7
  AST_SUM_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_STATUS) |-> (reg_rdata_o[SUM_BIT] == (sts[W-1:ERR_LO] != '0)))
    else $error("summary wrong"); // R4
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic [31:0] evt = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .soft_clr_i(soft_clr), .evt_i(evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {event, capture-enable, expected status}
  localparam logic [95:0] VEC [6] = '{
    {32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001},
    {32'h3077_0033, 32'hFFFF_FFFF, 32'h3077_8033},
    {32'hFFFF_FFFF, 32'h0000_0033, 32'h0000_0033},
    {32'hCF88_7FCC, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0010_0000, 32'h0010_0000, 32'h0010_8000},
    {32'h2000_0010, 32'h0000_0010, 32'h0000_0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic sclr();
    @(negedge clk); soft_clr = 1'b1;
    @(negedge clk); soft_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(2'd0, r); chk("R10 status", r, 32'h0);
    rd(2'd1, r); chk("R10 sts_en", r, 32'h0);
    rd(2'd2, r); chk("R10 sig_en", r, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);

    // R1 R2 R7 R4 table walk
    for (int i = 0; i < 6; i++) begin
      sclr();
      wr(2'd1, VEC[i][63:32]);
      pulse(VEC[i][95:64]);
      rd(2'd0, r);
      chk($sformatf("R1/R2/R7 vec%0d", i), r, VEC[i][31:0]);
    end

    // R6 enable masks, R7 unmapped address
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); chk("R6 sts_en mask", r, 32'h3077_0033);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r); chk("R6 sig_en mask", r, 32'h3077_8033);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, r); chk("R7 addr3", r, 32'h0);
    wr(2'd2, 32'h0);

    // R3 write-one-to-clear
    sclr();
    pulse(32'h0000_0033);
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, r); chk("R3 w1c", r, 32'h0000_0032);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, r); chk("R3 w0 keeps", r, 32'h0000_0032);

    // R4 summary bit ignores writes, tracks error half
    pulse(32'h0001_0000);
    wr(2'd0, 32'h0000_8000);
    rd(2'd0, r); chk("R4 sum write ignored", r, 32'h0001_8032);
    wr(2'd0, 32'h0001_0000);
    rd(2'd0, r); chk("R4 sum drops", r, 32'h0000_0032);

    // R5 event beats same-cycle clear
    @(negedge clk); evt = 32'h0000_0010; we = 1'b1; addr = 2'd0; wdata = 32'h0000_0010;
    @(negedge clk); evt = '0; we = 1'b0; wdata = '0;
    rd(2'd0, r); chk("R5 event wins", r, 32'h0000_0032);

    // R8 interrupt line
    sclr();
    pulse(32'h0000_0001);
    @(negedge clk);
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h0000_0001);
    @(negedge clk);
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0001);
    @(negedge clk);
    chk("R8 irq off", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h0000_8000);
    pulse(32'h2000_0000);
    @(negedge clk);
    chk("R8 irq via summary", {31'b0, irq}, 32'h1);

    // R9 soft clear keeps enables
    sclr();
    rd(2'd0, r); chk("R9 status cleared", r, 32'h0);
    rd(2'd1, r); chk("R9 sts_en kept", r, 32'h3077_0033);
    rd(2'd2, r); chk("R9 sig_en kept", r, 32'h0000_8000);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule